// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out space in a shared packet RAM that is divided into fixed-size pages. A host asks for a number of bytes, and the allocator works out how many pages that needs, counting a small header reserve on top of the payload. It then looks for a contiguous run of free pages. The first page of the run doubles as the packet number. The search can finish at once or much later: when too few pages are free the request waits, and it is retried as pages come back. The grant is reported through a result register with a failure flag and through a sticky interrupt bit. That bit can be polled, or it can be unmasked to drive an interrupt line.

Pages come back in two ways. The host can issue an explicit release that names a packet number. The transmit path can also report that a packet has finished, and when automatic release is enabled a successful finish frees that packet's pages. A release that names a number which is not the head of a live packet is ignored.

The allocate command is a valid/ready stream. A command transfers on a rising edge where `alloc_valid` and `alloc_ready` are both high. While a request is waiting for pages, `alloc_ready` stays low, which holds back any further command. The host must keep `alloc_valid` and `alloc_bytes` steady until the transfer happens. Release inputs are plain one-cycle strobes and are always taken.

Top module: `pkt_page_alloc`

## Requirements
- R1: A request for N bytes occupies ceil((N+6)/256) contiguous pages. With 8 pages of 256 bytes, 250 bytes takes 1 page, 251 to 506 bytes take 2 pages, and 2042 bytes takes all 8 pages.
- R2: The granted run is the lowest-indexed run of free pages that is long enough. `alloc_pnum` reports the index of the run's first page.
- R3: `alloc_ready` is high when no request is waiting and low from the edge that accepts a fitting request until the edge that grants it.
- R4: Accepting a command sets `alloc_fail` to 1. The grant clears `alloc_fail` to 0 and loads `alloc_pnum`. The earliest grant is the second rising edge after the command is presented, that is, one edge after acceptance.
- R5: A waiting request is retried on every cycle. It is granted on the first edge after a release leaves enough contiguous pages free.
- R6: `alloc_int` is set on the grant edge. `irq` equals `alloc_int` gated by `alloc_int_en`.
- R7: A strobe on `alloc_int_clr` clears `alloc_int`. If a grant happens in the same cycle, the set wins.
- R8: A host release (`rel_valid`) that names a live packet's number frees every page of that packet.
- R9: A release that names a page which is not the first page of a live packet (a free page or an inner page) has no effect.
- R10: A transmit-completion strobe frees the named packet only when `auto_release` is 1 and `txc_ok` is 1. Otherwise it has no effect.
- R11: A request that needs more than 8 pages (N above 2042) is accepted and dropped. `alloc_fail` goes to 1, nothing waits, `alloc_ready` stays high and `alloc_int` is not set.
- R12: After reset all pages are free, `alloc_ready`=1, `alloc_fail`=0, `alloc_pnum`=0, `alloc_int`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate command valid |
| alloc_ready | output | 1 | Allocator can take a command |
| alloc_bytes | input | 11 | Requested size in bytes |
| alloc_fail | output | 1 | Result failure flag |
| alloc_pnum | output | 3 | Granted packet number |
| alloc_int | output | 1 | Sticky allocation-done status |
| alloc_int_en | input | 1 | Interrupt mask for alloc_int |
| alloc_int_clr | input | 1 | Write-one-to-clear strobe for alloc_int |
| rel_valid | input | 1 | Host release strobe |
| rel_pnum | input | 3 | Packet number to release |
| auto_release | input | 1 | Free packets on successful transmit completion |
| txc_valid | input | 1 | Transmit completion strobe |
| txc_ok | input | 1 | Completed transmission succeeded |
| txc_pnum | input | 3 | Packet number that completed |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest state to reach is a request that is left waiting on a fragmented map. In that state the free pages add up to less than the request, or they are split into runs that are each too short. The stimulus builds this on purpose. It packs the RAM, frees inner and head pages in a chosen order, and lets failed or masked transmit completions go by. It then issues a three-page request while only one page is free. The bench checks that the request is still waiting after several cycles. It then releases a neighbouring packet and checks that the grant lands exactly one edge later, at the first page of the merged run. Each completed grant is compared against the scoreboard queue, so a first-fit error or a wrongly honoured release shows up as a packet-number mismatch.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;

  // request tracking state of the allocator front end
  typedef enum logic {
    REQ_IDLE = 1'b0,
    REQ_WAIT = 1'b1
  } req_state_e;

  // number of release sources feeding the page map
  localparam int unsigned REL_SOURCES = 2;

endpackage

// File: rtl/pg_sizer.sv
module pg_sizer #(
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned HDR_BYTES  = 6,
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned CNT_W      = 4
) (
  input  logic [LEN_W-1:0] bytes,
  output logic [CNT_W-1:0] pages,
  output logic             too_big
);

  localparam logic [31:0] ROUND_ADD = 32'(HDR_BYTES + PAGE_BYTES - 1);

  logic [31:0] sum_w;
  logic [31:0] full_w;

  always_comb begin
    sum_w   = 32'(bytes) + ROUND_ADD;
    full_w  = sum_w / 32'(PAGE_BYTES);
    too_big = (full_w > 32'(NUM_PAGES));
    pages   = too_big ? '0 : full_w[CNT_W-1:0];
  end

endmodule

// File: rtl/pg_fit.sv
module pg_fit #(
  parameter int unsigned NUM_PAGES = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned PN_W      = 3
) (
  input  logic [NUM_PAGES-1:0] used,
  input  logic [CNT_W-1:0]     req_pages,
  output logic                 found,
  output logic [PN_W-1:0]      start,
  output logic [NUM_PAGES-1:0] grant_mask
);

  logic [NUM_PAGES-1:0] fits;

  // one window per candidate start page
  for (genvar s = 0; s < NUM_PAGES; s++) begin : g_start
    logic [NUM_PAGES-1:0] win;
    always_comb begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        win[p] = (p >= s) && (32'(p) < 32'(s) + 32'(req_pages));
      end
    end
    assign fits[s] = (req_pages != '0) &&
                     (32'(s) + 32'(req_pages) <= 32'(NUM_PAGES)) &&
                     ((used & win) == '0);
  end

  // lowest fitting start wins
  always_comb begin
    found = 1'b0;
    start = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (fits[i]) begin
        found = 1'b1;
        start = PN_W'(i);
      end
    end
    for (int p = 0; p < NUM_PAGES; p++) begin
      grant_mask[p] = found && (32'(p) >= 32'(start)) &&
                      (32'(p) < 32'(start) + 32'(req_pages));
    end
  end

endmodule

// File: rtl/pg_map.sv
module pg_map
  import pgalloc_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned PN_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant,
  input  logic [PN_W-1:0]      grant_start,
  input  logic [CNT_W-1:0]     grant_pages,
  input  logic [NUM_PAGES-1:0] grant_mask,
  input  logic                 rel_a_valid,
  input  logic [PN_W-1:0]      rel_a_pnum,
  input  logic                 rel_b_valid,
  input  logic [PN_W-1:0]      rel_b_pnum,
  output logic [NUM_PAGES-1:0] used
);

  logic [NUM_PAGES-1:0] used_q;
  logic [NUM_PAGES-1:0] head_q;
  logic [CNT_W-1:0]     len_q [NUM_PAGES];

  logic [REL_SOURCES-1:0] rel_v;
  logic [PN_W-1:0]        rel_p [REL_SOURCES];
  logic [NUM_PAGES-1:0]   free_m [REL_SOURCES];
  logic [NUM_PAGES-1:0]   head_clr [REL_SOURCES];

  assign rel_v[0] = rel_a_valid;
  assign rel_v[1] = rel_b_valid;
  assign rel_p[0] = rel_a_pnum;
  assign rel_p[1] = rel_b_pnum;

  // each source frees the run of a live head only
  for (genvar r = 0; r < REL_SOURCES; r++) begin : g_rel
    logic hit;
    assign hit = rel_v[r] && head_q[rel_p[r]];
    always_comb begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        free_m[r][p]   = hit && (32'(p) >= 32'(rel_p[r])) &&
                         (32'(p) < 32'(rel_p[r]) + 32'(len_q[rel_p[r]]));
        head_clr[r][p] = hit && (32'(p) == 32'(rel_p[r]));
      end
    end
  end

  logic [NUM_PAGES-1:0] free_all;
  logic [NUM_PAGES-1:0] clr_all;
  logic [NUM_PAGES-1:0] head_set;

  always_comb begin
    free_all = '0;
    clr_all  = '0;
    for (int r = 0; r < REL_SOURCES; r++) begin
      free_all = free_all | free_m[r];
      clr_all  = clr_all | head_clr[r];
    end
    head_set = '0;
    if (grant) head_set[grant_start] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      head_q <= '0;
      for (int i = 0; i < NUM_PAGES; i++) len_q[i] <= '0;
    end else begin
      used_q <= (used_q & ~free_all) | (grant ? grant_mask : '0);
      head_q <= (head_q & ~clr_all) | head_set;
      if (grant) len_q[grant_start] <= grant_pages;
    end
  end

  assign used = used_q;

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pgalloc_pkg::*;
#(
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned HDR_BYTES  = 6,
  parameter int unsigned NUM_PAGES  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  output logic                         alloc_ready,
  input  logic [LEN_W-1:0]             alloc_bytes,
  output logic                         alloc_fail,
  output logic [$clog2(NUM_PAGES)-1:0] alloc_pnum,
  output logic                         alloc_int,
  input  logic                         alloc_int_en,
  input  logic                         alloc_int_clr,
  input  logic                         rel_valid,
  input  logic [$clog2(NUM_PAGES)-1:0] rel_pnum,
  input  logic                         auto_release,
  input  logic                         txc_valid,
  input  logic                         txc_ok,
  input  logic [$clog2(NUM_PAGES)-1:0] txc_pnum,
  output logic                         irq
);

  localparam int unsigned PN_W  = $clog2(NUM_PAGES);
  localparam int unsigned CNT_W = $clog2(NUM_PAGES + 1);

  req_state_e             state_q;
  logic [CNT_W-1:0]       need_q;
  logic                   fail_q;
  logic [PN_W-1:0]        pnum_q;
  logic                   int_q;

  logic [CNT_W-1:0]       size_pages;
  logic                   size_big;
  logic [NUM_PAGES-1:0]   used;
  logic                   fit_found;
  logic [PN_W-1:0]        fit_start;
  logic [NUM_PAGES-1:0]   fit_mask;
  logic                   accept;
  logic                   grant;
  logic                   txc_free;

  pg_sizer #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .HDR_BYTES(HDR_BYTES),
    .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)
  ) u_sizer (
    .bytes(alloc_bytes), .pages(size_pages), .too_big(size_big)
  );

  pg_fit #(
    .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W), .PN_W(PN_W)
  ) u_fit (
    .used(used), .req_pages(need_q), .found(fit_found),
    .start(fit_start), .grant_mask(fit_mask)
  );

  assign alloc_ready = (state_q == REQ_IDLE);
  assign accept      = alloc_valid && alloc_ready;
  assign grant       = (state_q == REQ_WAIT) && fit_found;
  assign txc_free    = txc_valid && txc_ok && auto_release;

  pg_map #(
    .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W), .PN_W(PN_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .grant(grant), .grant_start(fit_start), .grant_pages(need_q),
    .grant_mask(fit_mask),
    .rel_a_valid(rel_valid), .rel_a_pnum(rel_pnum),
    .rel_b_valid(txc_free), .rel_b_pnum(txc_pnum),
    .used(used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= REQ_IDLE;
      need_q  <= '0;
      fail_q  <= 1'b0;
      pnum_q  <= '0;
      int_q   <= 1'b0;
    end else begin
      if (accept) begin
        fail_q <= 1'b1;
        if (!size_big) begin
          state_q <= REQ_WAIT;
          need_q  <= size_pages;
        end
      end else if (grant) begin
        state_q <= REQ_IDLE;
        fail_q  <= 1'b0;
        pnum_q  <= fit_start;
      end
      if (grant)              int_q <= 1'b1;
      else if (alloc_int_clr) int_q <= 1'b0;
    end
  end

  assign alloc_fail = fail_q;
  assign alloc_pnum = pnum_q;
  assign alloc_int  = int_q;
  assign irq        = int_q && alloc_int_en;

endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk #(
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned HDR_BYTES  = 6,
  parameter int unsigned NUM_PAGES  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [LEN_W-1:0] alloc_bytes,
  input logic             alloc_fail,
  input logic             alloc_int,
  input logic             alloc_int_clr
);

  localparam logic [31:0] MAX_FIT = 32'(NUM_PAGES * PAGE_BYTES - HDR_BYTES);

  // R3: a fitting request blocks further commands on the next cycle
  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && 32'(alloc_bytes) <= MAX_FIT) |=> !alloc_ready);

  // R4: any accepted command raises the failure flag
  p_accept_sets_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_fail);

  // R6: a fresh interrupt always comes with a successful result
  p_int_means_success_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_int) |-> !alloc_fail);

  // R7: with no request waiting, a clear strobe empties the status bit
  p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_int_clr && alloc_ready) |=> !alloc_int);

  // R11: an oversize request never blocks the command stream
  p_oversize_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && 32'(alloc_bytes) > MAX_FIT) |=> alloc_ready);

endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(
  .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .HDR_BYTES(HDR_BYTES),
  .NUM_PAGES(NUM_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready), .alloc_bytes(alloc_bytes),
  .alloc_fail(alloc_fail), .alloc_int(alloc_int),
  .alloc_int_clr(alloc_int_clr)
);

// File: tb/pkt_page_alloc_tb.sv
module pkt_page_alloc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0;
  logic       alloc_ready;
  logic [10:0] alloc_bytes = '0;
  logic       alloc_fail;
  logic [2:0] alloc_pnum;
  logic       alloc_int;
  logic       alloc_int_en = 1'b0;
  logic       alloc_int_clr = 1'b0;
  logic       rel_valid = 1'b0;
  logic [2:0] rel_pnum = '0;
  logic       auto_release = 1'b0;
  logic       txc_valid = 1'b0;
  logic       txc_ok = 1'b0;
  logic [2:0] txc_pnum = '0;
  logic       irq;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  logic prev_ready = 1'b1;

  always #4 clk = ~clk;

  pkt_page_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .alloc_ready(alloc_ready), .alloc_bytes(alloc_bytes),
    .alloc_fail(alloc_fail), .alloc_pnum(alloc_pnum),
    .alloc_int(alloc_int), .alloc_int_en(alloc_int_en),
    .alloc_int_clr(alloc_int_clr), .rel_valid(rel_valid),
    .rel_pnum(rel_pnum), .auto_release(auto_release),
    .txc_valid(txc_valid), .txc_ok(txc_ok), .txc_pnum(txc_pnum),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: a rising ready marks a completed grant
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_ready && alloc_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected grant", int'(alloc_pnum), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(alloc_pnum == 3'(e), "R2 packet number", int'(alloc_pnum), e);
          chk(!alloc_fail, "R4 fail cleared on grant", int'(alloc_fail), 0);
          chk(alloc_int, "R6 int set on grant", int'(alloc_int), 1);
        end
      end
      prev_ready = alloc_ready;
    end
  end

  task automatic clear_int();
    @(posedge clk); #1 alloc_int_clr = 1'b1;
    @(posedge clk); #1 alloc_int_clr = 1'b0;
    @(negedge clk);
    chk(!alloc_int, "R7 clear strobe", int'(alloc_int), 0);
  endtask

  task automatic issue(input int bytes);
    @(posedge clk); #1 alloc_valid = 1'b1; alloc_bytes = 11'(bytes);
    @(posedge clk); #1 alloc_valid = 1'b0;
  endtask

  // driver: push the expected number, send the command, wait for the grant
  task automatic alloc_ok(input int bytes, input int exp);
    clear_int();
    exp_q.push_back(exp);
    issue(bytes);
    @(negedge clk);
    chk(!alloc_ready, "R3 ready low while waiting", int'(alloc_ready), 0);
    chk(alloc_fail, "R4 fail set on accept", int'(alloc_fail), 1);
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R1 grant arrived", exp_q.size(), 0);
  endtask

  task automatic host_rel(input int pn);
    @(posedge clk); #1 rel_valid = 1'b1; rel_pnum = 3'(pn);
    @(posedge clk); #1 rel_valid = 1'b0;
  endtask

  task automatic tx_done(input int pn, input bit ok);
    @(posedge clk); #1 txc_valid = 1'b1; txc_pnum = 3'(pn); txc_ok = ok;
    @(posedge clk); #1 txc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(alloc_ready, "R12 ready", int'(alloc_ready), 1);
    chk(!alloc_fail, "R12 fail", int'(alloc_fail), 0);
    chk(alloc_pnum == 0, "R12 pnum", int'(alloc_pnum), 0);
    chk(!alloc_int && !irq, "R12 int", int'(alloc_int), 0);

    // R1 R2 sizing at the one/two page boundary, first fit from page 0
    alloc_ok(250, 0);          // page 0
    alloc_ok(251, 1);          // pages 1-2
    alloc_ok(506, 3);          // pages 3-4

    // R6 mask gating
    @(negedge clk);
    chk(alloc_int && !irq, "R6 masked irq", int'(irq), 0);
    @(posedge clk); #1 alloc_int_en = 1'b1;
    @(negedge clk);
    chk(irq, "R6 unmasked irq", int'(irq), 1);
    clear_int();
    chk(!irq, "R7 irq after clear", int'(irq), 0);

    // R8 free packet 1; R9 inner page 4 and free page 7 ignored
    host_rel(1);
    host_rel(4);
    host_rel(7);
    alloc_ok(600, 5);          // 3 pages: 1-2 too short, 4 still held -> 5
    // now used 0,3,4,5,6,7 ; free 1,2

    // R10 completion ignored with auto release off
    tx_done(0, 1'b1);
    alloc_ok(10, 1);           // page 0 still held
    // R10 failed completion ignored, successful one frees 3-4
    @(posedge clk); #1 auto_release = 1'b1;
    tx_done(0, 1'b0);
    tx_done(3, 1'b1);
    alloc_ok(300, 2);          // pages 2-3
    // used 0,1,2,3,5,6,7 ; free 4

    // R5 waiting request, granted one edge after the release
    clear_int();
    exp_q.push_back(4);
    issue(600);
    repeat (5) @(negedge clk);
    chk(!alloc_ready && alloc_fail, "R5 still waiting", int'(alloc_ready), 0);
    chk(!alloc_int, "R5 no int while waiting", int'(alloc_int), 0);
    @(posedge clk); #1 rel_valid = 1'b1; rel_pnum = 3'd5;
    @(posedge clk); #1 rel_valid = 1'b0;
    @(negedge clk);
    chk(!alloc_ready, "R5 not before map update", int'(alloc_ready), 0);
    @(negedge clk);
    chk(alloc_ready, "R5 grant one edge after release", int'(alloc_ready), 1);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 grant popped", exp_q.size(), 0);

    // R11 oversize request dropped
    clear_int();
    issue(2043);
    @(negedge clk);
    chk(alloc_ready, "R11 ready stays high", int'(alloc_ready), 1);
    chk(alloc_fail, "R11 fail flag", int'(alloc_fail), 1);
    repeat (3) @(negedge clk);
    chk(!alloc_int, "R11 no int", int'(alloc_int), 0);

    // R8 R1 free everything, then the largest fitting request takes all pages
    host_rel(0);
    host_rel(1);
    host_rel(2);
    host_rel(4);
    alloc_ok(2042, 0);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule